// File: doc/BRIEF.md
# Two-Way Instruction Cache with Virtual Index and Physical Tag

This block is a two-way set-associative instruction cache of 8 KB. A fetch presents a virtual address together with the physical page number that translation produces in the same cycle. The set is chosen from virtual address bits that lie inside the page offset, so the array read starts without waiting for translation. The physical page number is then compared against the stored tags of both ways. A lookup reads one 64-bit word and returns the 32-bit half that the fetch asked for. A fetch that lands in the same 64-bit word as the previous hit is served from a held copy, and the arrays are not read.

On a miss, including a tag or data parity failure, the cache reports the miss and raises a line request. It takes four 64-bit refill beats, each with a parity bit, writes them into the chosen way, and marks the line valid only with the last beat. It then replays the stalled fetch internally, so the requester sees a hit response. An invalidate port clears one way of one set.

Top module: `vipt_icache`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` is 1, and `resp_valid` and `miss_req` are 0.
- R2: A fetch accepted on a clock edge (`fetch_valid` and `fetch_ready` both 1) gives `resp_valid` after that edge. On a hit, `resp_instr` is bits 31:0 of the addressed 64-bit word when `fetch_vaddr[2]` is 0, and bits 63:32 when it is 1.
- R3: The set is `fetch_vaddr[11:5]` and the word within the line is `fetch_vaddr[4:3]`. A hit requires `fetch_ptag` to equal the stored tag of a valid way. `fetch_vaddr[31:12]` takes no part in the hit decision.
- R4: A missed lookup gives `resp_valid`=1 with `resp_hit`=0. From the next edge `miss_req` is 1 and `miss_addr` is {`fetch_ptag`, set, 5'b0}, held until the line has been taken.
- R5: A refill takes exactly four beats (`refill_valid`=1 while `miss_req`=1), in word order 0 to 3. `miss_req` drops after the fourth beat. The replayed fetch responds after the second edge following the fourth beat and hits with that line's data.
- R6: A fill goes to way 0 if it is invalid, otherwise to way 1 if that is invalid, otherwise to the least recently used way. Every hit and every completed fill makes the other way the least recently used.
- R7: A fetch whose `fetch_vaddr[31:3]` and `fetch_ptag` equal those of the last word that hit, with no invalidate in between, holds `array_rd` at 0 and hits with that word.
- R8: Each refill beat is stored with `refill_par`. A stored word whose bit is not the XOR of its 64 data bits, or a tag failing its parity, gives `par_err`=1 with `resp_hit`=0 and refills the affected way.
- R9: `inv_valid` clears the valid bit of way `inv_way` in set `inv_set` and stops reuse of the held word. The other way of that set keeps its line.
- R10: From the missed response until the replay response, `fetch_ready` is 0 and `fetch_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_vaddr | input | 32 | Virtual fetch address |
| fetch_ptag | input | 20 | Physical page number from translation |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| array_rd | output | 1 | Tag and data arrays are read this cycle |
| resp_valid | output | 1 | Response for the fetch of the previous edge |
| resp_hit | output | 1 | Response carries a valid instruction |
| resp_instr | output | 32 | Instruction word |
| par_err | output | 1 | Tag or data parity failure on this lookup |
| miss_req | output | 1 | Line refill wanted |
| miss_addr | output | 32 | Physical line address of the refill |
| refill_valid | input | 1 | Refill beat present |
| refill_data | input | 64 | Refill beat data |
| refill_par | input | 1 | Parity bit of the refill beat |
| inv_valid | input | 1 | Invalidate request |
| inv_set | input | 7 | Set to invalidate |
| inv_way | input | 1 | Way to invalidate |

## Verification
The bench builds the cache with its default parameters: 128 sets, four 64-bit words per line and a 20-bit physical tag, so the set index is exactly the address bits below the 4 KB page number. With those values, changing only the virtual page bits shows that the index comes from inside the page offset, and changing only the physical tag on the same index forces a miss. Three tags on one set reach eviction under the recency bit. A refill beat with a wrong parity bit lets the data check be seen at the ports.

// File: rtl/vipt_icache_pkg.sv
// Package: shared constants and types of the two-way instruction cache.
// Assumes: exactly two ways (one recency bit per set), 64-bit storage words.
package vipt_icache_pkg;

    localparam int WAYS    = 2;
    localparam int WORD_W  = 64;
    localparam int INSTR_W = 32;
    localparam int BYTE_OFS_W = 3;   // byte offset inside a storage word

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_REPLAY = 2'd2
    } fill_state_t;

endpackage

// File: rtl/icache_tag_way.sv
// Module: tag store of one way. Holds a physical tag plus its parity bit per
// set and a resettable valid vector. Reads are registered (one-cycle latency);
// a read and write of the same set on one edge return the old entry.
// Assumes: the caller never writes and reads with conflicting intent.
module icache_tag_way #(
    parameter int SETS   = 128,
    parameter int PTAG_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [$clog2(SETS)-1:0]  rd_set,
    input  logic                     wr_en,
    input  logic [$clog2(SETS)-1:0]  wr_set,
    input  logic                     wr_valid,
    input  logic [PTAG_W-1:0]        wr_tag,
    output logic                     rd_valid,
    output logic [PTAG_W-1:0]        rd_tag,
    output logic                     rd_perr
);
    logic [SETS-1:0]   valid_q;
    logic [PTAG_W:0]   tag_mem [SETS];
    logic [PTAG_W:0]   entry_q;

    // Valid bits: cleared by reset, written with each tag write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_set] <= wr_valid;
    end

    // Tag storage: parity bit stored above the tag.
    always_ff @(posedge clk) begin
        if (wr_en)
            tag_mem[wr_set] <= {^wr_tag, wr_tag};
    end

    // Registered valid read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else if (rd_en)
            rd_valid <= valid_q[rd_set];
    end

    // Registered tag read.
    always_ff @(posedge clk) begin
        if (rd_en)
            entry_q <= tag_mem[rd_set];
    end

    // Parity check, meaningful only on a valid entry.
    assign rd_tag  = entry_q[PTAG_W-1:0];
    assign rd_perr = rd_valid && ((^entry_q[PTAG_W-1:0]) != entry_q[PTAG_W]);

endmodule

// File: rtl/icache_data_way.sv
// Module: data store of one way, one 64-bit word plus parity per entry,
// addressed by {set, word}. The parity bit comes from the refill source and is
// checked on every registered read.
// Assumes: reads of never-written entries are only used behind a clear valid bit.
module icache_data_way
    import vipt_icache_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rd_en,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
    input  logic                          wr_en,
    input  logic [$clog2(SETS)-1:0]       wr_set,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic                          wr_par,
    output logic [WORD_W-1:0]             rd_data,
    output logic                          rd_perr
);
    localparam int DEPTH = SETS * LINE_WORDS;

    logic [WORD_W:0] mem [DEPTH];
    logic [WORD_W:0] word_q;

    // Refill write of one word and its parity.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_set, wr_word}] <= {wr_par, wr_data};
    end

    // Registered lookup read.
    always_ff @(posedge clk) begin
        if (rd_en)
            word_q <= mem[{rd_set, rd_word}];
    end

    assign rd_data = word_q[WORD_W-1:0];
    assign rd_perr = (^word_q[WORD_W-1:0]) != word_q[WORD_W];

endmodule

// File: rtl/icache_ctrl.sv
// Module: miss handling. Captures a missed fetch, picks the victim way,
// clears its tag, counts refill beats into the data store, sets the tag on the
// last beat, then issues one replay lookup. Also keeps the per-set recency bit.
// Assumes: the top only reports a miss while this controller is idle.
module icache_ctrl
    import vipt_icache_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4,
    parameter int PTAG_W     = 20,
    parameter int VA_W       = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s1_miss,
    input  logic                          s1_hit_upd,
    input  logic                          s1_hit_way,
    input  logic [VA_W-1:2]               s1_va,
    input  logic [PTAG_W-1:0]             s1_pt,
    input  logic [WAYS-1:0]               way_valid,
    input  logic                          err_v,
    input  logic                          err_way,
    input  logic                          refill_valid,
    output logic                          idle,
    output logic                          replay_go,
    output logic [VA_W-1:2]               replay_va,
    output logic [PTAG_W-1:0]             replay_pt,
    output logic                          fill_we,
    output logic                          fill_way,
    output logic [$clog2(SETS)-1:0]       fill_set,
    output logic [$clog2(LINE_WORDS)-1:0] fill_word,
    output logic                          tag_we,
    output logic                          tag_way,
    output logic [$clog2(SETS)-1:0]       tag_set,
    output logic                          tag_valid,
    output logic [PTAG_W-1:0]             tag_val,
    output logic                          miss_req,
    output logic [VA_W-1:0]               miss_addr
);
    localparam int SET_W  = $clog2(SETS);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFS_W  = WSEL_W + BYTE_OFS_W;
    localparam int SET_LO = OFS_W;
    localparam int SET_HI = OFS_W + SET_W - 1;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    fill_state_t        state_q;
    logic [VA_W-1:2]    m_va;
    logic [PTAG_W-1:0]  m_pt;
    logic               m_way;
    logic [WSEL_W-1:0]  beat_q;
    logic [SETS-1:0]    lru_q;
    logic               victim;
    logic               last_beat;
    logic [SET_W-1:0]   s1_set;
    logic [SET_W-1:0]   m_set;

    assign s1_set    = s1_va[SET_HI:SET_LO];
    assign m_set     = m_va[SET_HI:SET_LO];
    assign idle      = (state_q == ST_IDLE);
    assign miss_req  = (state_q == ST_FILL);
    assign replay_go = (state_q == ST_REPLAY);
    assign last_beat = miss_req && refill_valid && (beat_q == LAST_BEAT);

    // Victim choice: failing way, then an invalid way, then the recency bit.
    always_comb begin
        if (err_v)
            victim = err_way;
        else if (!way_valid[0])
            victim = 1'b0;
        else if (!way_valid[1])
            victim = 1'b1;
        else
            victim = lru_q[s1_set];
    end

    // Sequencer: idle -> fill (count beats) -> replay -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (s1_miss) begin
                    state_q <= ST_FILL;
                    beat_q  <= '0;
                end
                ST_FILL: if (refill_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT)
                        state_q <= ST_REPLAY;
                end
                ST_REPLAY: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Missed request capture.
    always_ff @(posedge clk) begin
        if (idle && s1_miss) begin
            m_va  <= s1_va;
            m_pt  <= s1_pt;
            m_way <= victim;
        end
    end

    // Recency bit: the way just used becomes most recent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else if (last_beat)
            lru_q[m_set] <= ~m_way;
        else if (s1_hit_upd)
            lru_q[s1_set] <= ~s1_hit_way;
    end

    // Array write controls.
    always_comb begin
        fill_we   = miss_req && refill_valid;
        fill_way  = m_way;
        fill_set  = m_set;
        fill_word = beat_q;
        tag_we    = (idle && s1_miss) || last_beat;
        tag_way   = idle ? victim : m_way;
        tag_set   = idle ? s1_set : m_set;
        tag_valid = !idle;
        tag_val   = m_pt;
    end

    assign replay_va = m_va;
    assign replay_pt = m_pt;
    assign miss_addr = {m_pt, m_set, {OFS_W{1'b0}}};

endmodule

// File: rtl/vipt_icache.sv
// Module: top of the two-way instruction cache. Stage 0 indexes both ways
// with virtual address bits; stage 1 compares the registered physical tag,
// checks parity, selects the 32-bit half and drives the response. A held copy
// of the last hit word serves fetches to the same 64-bit word without an
// array read. Misses are handed to icache_ctrl.
// Assumes: set index plus word offset lie within the page offset, so the
// physical page number alone forms the tag.
module vipt_icache
    import vipt_icache_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4,
    parameter int PTAG_W     = 20,
    parameter int VA_W       = PTAG_W + $clog2(SETS) + $clog2(LINE_WORDS) + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fetch_valid,
    input  logic [VA_W-1:0]          fetch_vaddr,
    input  logic [PTAG_W-1:0]        fetch_ptag,
    output logic                     fetch_ready,
    output logic                     array_rd,
    output logic                     resp_valid,
    output logic                     resp_hit,
    output logic [INSTR_W-1:0]       resp_instr,
    output logic                     par_err,
    output logic                     miss_req,
    output logic [VA_W-1:0]          miss_addr,
    input  logic                     refill_valid,
    input  logic [WORD_W-1:0]        refill_data,
    input  logic                     refill_par,
    input  logic                     inv_valid,
    input  logic [$clog2(SETS)-1:0]  inv_set,
    input  logic                     inv_way
);
    localparam int SET_W  = $clog2(SETS);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFS_W  = WSEL_W + BYTE_OFS_W;
    localparam int SET_LO = OFS_W;
    localparam int SET_HI = OFS_W + SET_W - 1;

    // Stage 1 state.
    logic               s1_valid, s1_reuse;
    logic [VA_W-1:2]    s1_va;
    logic [PTAG_W-1:0]  s1_pt;

    // Held word for reuse.
    logic               wb_valid;
    logic [VA_W-1:3]    wb_a;
    logic [PTAG_W-1:0]  wb_p;
    logic [WORD_W-1:0]  wb_data;

    // Controller interface.
    logic               c_idle, replay_go;
    logic [VA_W-1:2]    replay_va;
    logic [PTAG_W-1:0]  replay_pt;
    logic               fill_we, fill_way;
    logic [SET_W-1:0]   fill_set;
    logic [WSEL_W-1:0]  fill_word;
    logic               c_tag_we, c_tag_way, c_tag_valid;
    logic [SET_W-1:0]   c_tag_set;
    logic [PTAG_W-1:0]  c_tag_val;

    // Array read side.
    logic               accept, reuse_ok, rd_en;
    logic [VA_W-1:2]    rd_va;
    logic [SET_W-1:0]   rd_set;
    logic [WSEL_W-1:0]  rd_word;

    // Per-way results.
    logic [WAYS-1:0]    t_valid, t_perr, d_perr, match, t_we, d_we;
    logic [PTAG_W-1:0]  t_tag  [WAYS];
    logic [WORD_W-1:0]  d_word [WAYS];
    logic [SET_W-1:0]   t_wset;
    logic               t_wvalid;

    // Compare results.
    logic               any_match, hit_way, d_err, t_err, lookup_hit;
    logic               s1_hit, s1_miss, s1_lk_hit, err_way;
    logic [WORD_W-1:0]  sel_word;

    // Reuse target: the word hitting now, else the held word.
    logic               cur_v;
    logic [VA_W-1:3]    cur_a;
    logic [PTAG_W-1:0]  cur_p;

    // Reuse decision for the fetch at the next edge.
    always_comb begin
        if (s1_lk_hit) begin
            cur_v = 1'b1;
            cur_a = s1_va[VA_W-1:3];
            cur_p = s1_pt;
        end else begin
            cur_v = wb_valid;
            cur_a = wb_a;
            cur_p = wb_p;
        end
        reuse_ok = !inv_valid && cur_v
                && (fetch_vaddr[VA_W-1:3] == cur_a) && (fetch_ptag == cur_p);
    end

    assign fetch_ready = c_idle && !s1_miss;
    assign accept      = fetch_valid && fetch_ready;
    assign rd_en       = (accept && !reuse_ok) || replay_go;
    assign array_rd    = rd_en;
    assign rd_va       = replay_go ? replay_va : fetch_vaddr[VA_W-1:2];
    assign rd_set      = rd_va[SET_HI:SET_LO];
    assign rd_word     = rd_va[OFS_W-1:BYTE_OFS_W];

    // Tag write source: refill controller first, invalidate otherwise.
    assign t_wset   = c_tag_we ? c_tag_set : inv_set;
    assign t_wvalid = c_tag_we ? c_tag_valid : 1'b0;

    // One tag store and one data store per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign t_we[w] = c_tag_we ? (c_tag_way == 1'(w))
                                  : (inv_valid && (inv_way == 1'(w)));
        assign d_we[w] = fill_we && (fill_way == 1'(w));

        icache_tag_way #(.SETS(SETS), .PTAG_W(PTAG_W)) u_tag (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (rd_en),
            .rd_set   (rd_set),
            .wr_en    (t_we[w]),
            .wr_set   (t_wset),
            .wr_valid (t_wvalid),
            .wr_tag   (c_tag_val),
            .rd_valid (t_valid[w]),
            .rd_tag   (t_tag[w]),
            .rd_perr  (t_perr[w])
        );

        icache_data_way #(.SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_data (
            .clk     (clk),
            .rd_en   (rd_en),
            .rd_set  (rd_set),
            .rd_word (rd_word),
            .wr_en   (d_we[w]),
            .wr_set  (fill_set),
            .wr_word (fill_word),
            .wr_data (refill_data),
            .wr_par  (refill_par),
            .rd_data (d_word[w]),
            .rd_perr (d_perr[w])
        );

        assign match[w] = t_valid[w] && !t_perr[w] && (t_tag[w] == s1_pt);
    end

    // Physical tag compare, parity and word selection.
    always_comb begin
        any_match  = |match;
        hit_way    = !match[0];
        d_err      = d_perr[hit_way];
        t_err      = |t_perr;
        lookup_hit = any_match && !d_err;
        s1_lk_hit  = s1_valid && !s1_reuse && lookup_hit;
        s1_hit     = s1_valid && (s1_reuse || lookup_hit);
        s1_miss    = s1_valid && !s1_hit;
        if (t_perr[0])
            err_way = 1'b0;
        else if (t_perr[1])
            err_way = 1'b1;
        else
            err_way = hit_way;
        sel_word   = s1_reuse ? wb_data : d_word[hit_way];
    end

    assign resp_valid = s1_valid;
    assign resp_hit   = s1_hit;
    assign par_err    = s1_valid && !s1_reuse && (t_err || (any_match && d_err));
    assign resp_instr = s1_va[2] ? sel_word[WORD_W-1:INSTR_W] : sel_word[INSTR_W-1:0];

    // Stage 1 control flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_reuse <= 1'b0;
        end else begin
            s1_valid <= accept || replay_go;
            s1_reuse <= accept && reuse_ok;
        end
    end

    // Stage 1 request capture.
    always_ff @(posedge clk) begin
        if (accept || replay_go) begin
            s1_va <= rd_va;
            s1_pt <= replay_go ? replay_pt : fetch_ptag;
        end
    end

    // Held word valid: dropped on any array change, set on a lookup hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wb_valid <= 1'b0;
        else if (inv_valid || c_tag_we || fill_we)
            wb_valid <= 1'b0;
        else if (s1_lk_hit)
            wb_valid <= 1'b1;
    end

    // Held word contents.
    always_ff @(posedge clk) begin
        if (s1_lk_hit) begin
            wb_a    <= s1_va[VA_W-1:3];
            wb_p    <= s1_pt;
            wb_data <= d_word[hit_way];
        end
    end

    icache_ctrl #(
        .SETS(SETS), .LINE_WORDS(LINE_WORDS), .PTAG_W(PTAG_W), .VA_W(VA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .s1_miss      (s1_miss),
        .s1_hit_upd   (s1_lk_hit),
        .s1_hit_way   (hit_way),
        .s1_va        (s1_va),
        .s1_pt        (s1_pt),
        .way_valid    (t_valid),
        .err_v        (t_err || (any_match && d_err)),
        .err_way      (err_way),
        .refill_valid (refill_valid),
        .idle         (c_idle),
        .replay_go    (replay_go),
        .replay_va    (replay_va),
        .replay_pt    (replay_pt),
        .fill_we      (fill_we),
        .fill_way     (fill_way),
        .fill_set     (fill_set),
        .fill_word    (fill_word),
        .tag_we       (c_tag_we),
        .tag_way      (c_tag_way),
        .tag_set      (c_tag_set),
        .tag_valid    (c_tag_valid),
        .tag_val      (c_tag_val),
        .miss_req     (miss_req),
        .miss_addr    (miss_addr)
    );

endmodule

// File: rtl/vipt_icache_checker.sv
// Module: protocol properties of the instruction cache, bound to the top.
// Assumes: observes top-level ports only; counts refill beats itself.
module vipt_icache_checker #(
    parameter int LINE_WORDS = 4,
    parameter int VA_W       = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_valid,
    input logic            fetch_ready,
    input logic            array_rd,
    input logic            resp_valid,
    input logic            resp_hit,
    input logic            par_err,
    input logic            miss_req,
    input logic [VA_W-1:0] miss_addr,
    input logic            refill_valid
);
    int unsigned beats;

    // Beat counter of the current refill.
    always_ff @(posedge clk) begin
        if (!rst_n || !miss_req)
            beats <= 0;
        else if (refill_valid)
            beats <= beats + 1;
    end

    p_resp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready) |=> resp_valid);

    p_req_after_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |=> miss_req);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && $past(miss_req)) |-> $stable(miss_addr));

    p_fill_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && refill_valid && beats == LINE_WORDS - 1) |=> !miss_req);

    p_replay_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && refill_valid && beats == LINE_WORDS - 1) |=> ##1 resp_valid);

    p_reuse_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && !array_rd) |=> (resp_valid && resp_hit));

    p_err_is_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (resp_valid && !resp_hit));

    p_ready_low_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> !fetch_ready);

endmodule

bind vipt_icache vipt_icache_checker #(.LINE_WORDS(LINE_WORDS), .VA_W(VA_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_ready  (fetch_ready),
    .array_rd     (array_rd),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .par_err      (par_err),
    .miss_req     (miss_req),
    .miss_addr    (miss_addr),
    .refill_valid (refill_valid)
);

// File: tb/test_vipt_icache.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, against a computed memory image.
module test_vipt_icache;
    localparam int VA_W   = 32;
    localparam int PT_W   = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [31:0]     fetch_vaddr = '0;
    logic [19:0]     fetch_ptag = '0;
    logic            fetch_ready, array_rd, resp_valid, resp_hit, par_err, miss_req;
    logic [31:0]     resp_instr, miss_addr;
    logic            refill_valid = 1'b0;
    logic [63:0]     refill_data = '0;
    logic            refill_par = 1'b0;
    logic            inv_valid = 1'b0;
    logic [6:0]      inv_set = '0;
    logic            inv_way = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int bad_beat = -1;

    always #2.5 clk = ~clk;

    vipt_icache i_vipt_icache (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_vaddr(fetch_vaddr), .fetch_ptag(fetch_ptag),
        .fetch_ready(fetch_ready), .array_rd(array_rd),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_instr(resp_instr),
        .par_err(par_err), .miss_req(miss_req), .miss_addr(miss_addr),
        .refill_valid(refill_valid), .refill_data(refill_data), .refill_par(refill_par),
        .inv_valid(inv_valid), .inv_set(inv_set), .inv_way(inv_way)
    );

    // Memory image: word at physical word address pw.
    function automatic logic [63:0] mem_word(input logic [31:0] pw);
        return {pw ^ 32'h5A5A_0F0F, pw};
    endfunction

    function automatic logic [31:0] exp_instr(input logic [31:0] va, input logic [19:0] pt);
        logic [31:0] pa;
        logic [63:0] w;
        pa = {pt, va[11:0]};
        w  = mem_word({pa[31:3], 3'b000});
        return pa[2] ? w[63:32] : w[31:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One fetch, serving any refills it causes. Reports the first response.
    task automatic do_fetch(input logic [31:0] va, input logic [19:0] pt, input bit poke,
                            output bit f_hit, output bit f_err, output bit f_rd,
                            output logic [31:0] instr, output logic [31:0] maddr,
                            output bit ready_seen);
        int guard;
        guard = 0;
        ready_seen = 1'b0;
        maddr = '0;
        while (!fetch_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        fetch_valid = 1'b1;
        fetch_vaddr = va;
        fetch_ptag  = pt;
        #1;
        f_rd = array_rd;
        @(negedge clk);
        fetch_valid = 1'b0;
        f_hit = resp_valid && resp_hit;
        f_err = par_err;
        instr = resp_instr;
        for (int k = 0; k < 3 && !(resp_valid && resp_hit); k++) begin
            @(negedge clk);
            if (k == 0) maddr = miss_addr;
            for (int b = 0; b < 4; b++) begin
                refill_valid = 1'b1;
                refill_data  = mem_word({miss_addr[31:5], 2'(b), 3'b000});
                refill_par   = (^refill_data) ^ (b == bad_beat);
                if (poke) begin
                    fetch_valid = 1'b1;
                    fetch_vaddr = ~va;
                    if (fetch_ready) ready_seen = 1'b1;
                end
                @(negedge clk);
            end
            bad_beat = -1;
            refill_valid = 1'b0;
            fetch_valid  = 1'b0;
            @(negedge clk);
            instr = resp_instr;
        end
        if (!(resp_valid && resp_hit)) begin
            chk(1'b0, "R5", "replay response never hit", {63'd0, resp_hit}, 64'd1);
        end
    endtask

    task automatic t_reset();
        chk(fetch_ready === 1'b1, "R1", "ready after reset", {63'd0, fetch_ready}, 64'd1);
        chk(resp_valid === 1'b0, "R1", "no response after reset", {63'd0, resp_valid}, 64'd0);
        chk(miss_req === 1'b0, "R1", "no miss after reset", {63'd0, miss_req}, 64'd0);
    endtask

    task automatic t_cold_miss();
        bit h, e, r, rs; logic [31:0] ins, ma;
        do_fetch(32'h0000_1040, 20'h12345, 1'b1, h, e, r, ins, ma, rs);
        chk(!h, "R4", "cold fetch misses", {63'd0, h}, 64'd0);
        chk(ma == {20'h12345, 7'd2, 5'd0}, "R4", "line address", ma, {20'h12345, 7'd2, 5'd0});
        chk(ins == exp_instr(32'h0000_1040, 20'h12345), "R5", "replayed word",
            ins, exp_instr(32'h0000_1040, 20'h12345));
        chk(!rs, "R10", "ready low during fill", {63'd0, rs}, 64'd0);
    endtask

    task automatic t_hit_and_reuse();
        bit h, e, r, rs; logic [31:0] ins, ma;
        do_fetch(32'h0000_105C, 20'h12345, 1'b0, h, e, r, ins, ma, rs);
        chk(h && r, "R2", "hit on filled line upper half", {62'd0, h, r}, 64'd3);
        chk(ins == exp_instr(32'h0000_105C, 20'h12345), "R2", "upper half word",
            ins, exp_instr(32'h0000_105C, 20'h12345));
        do_fetch(32'h0000_1058, 20'h12345, 1'b0, h, e, r, ins, ma, rs);
        chk(h && !r, "R7", "same word reused without array read", {62'd0, h, r}, 64'd2);
        chk(ins == exp_instr(32'h0000_1058, 20'h12345), "R2", "lower half word",
            ins, exp_instr(32'h0000_1058, 20'h12345));
        do_fetch(32'h0000_105C, 20'h12345, 1'b0, h, e, r, ins, ma, rs);
        chk(h && !r, "R7", "held word reused again", {62'd0, h, r}, 64'd2);
        chk(ins == exp_instr(32'h0000_105C, 20'h12345), "R7", "held word data",
            ins, exp_instr(32'h0000_105C, 20'h12345));
    endtask

    task automatic t_index_tag();
        bit h, e, r, rs; logic [31:0] ins, ma;
        do_fetch(32'hF000_1040, 20'h12345, 1'b0, h, e, r, ins, ma, rs);
        chk(h && r, "R3", "virtual page bits ignored", {62'd0, h, r}, 64'd3);
        chk(ins == exp_instr(32'h0000_1040, 20'h12345), "R3", "alias word",
            ins, exp_instr(32'h0000_1040, 20'h12345));
        do_fetch(32'h0000_1040, 20'h54321, 1'b0, h, e, r, ins, ma, rs);
        chk(!h, "R3", "other physical tag misses", {63'd0, h}, 64'd0);
        chk(ins == exp_instr(32'h0000_1040, 20'h54321), "R5", "second way word",
            ins, exp_instr(32'h0000_1040, 20'h54321));
        do_fetch(32'h0000_1048, 20'h12345, 1'b0, h, e, r, ins, ma, rs);
        chk(h, "R6", "first way kept after second fill", {63'd0, h}, 64'd1);
    endtask

    task automatic t_lru();
        bit h, e, r, rs; logic [31:0] ins, ma;
        do_fetch(32'h0000_00A0, 20'h00011, 1'b0, h, e, r, ins, ma, rs);
        do_fetch(32'h0000_00A0, 20'h00022, 1'b0, h, e, r, ins, ma, rs);
        do_fetch(32'h0000_00A8, 20'h00011, 1'b0, h, e, r, ins, ma, rs);
        chk(h, "R6", "first tag hits", {63'd0, h}, 64'd1);
        do_fetch(32'h0000_00A0, 20'h00033, 1'b0, h, e, r, ins, ma, rs);
        chk(!h, "R6", "third tag misses", {63'd0, h}, 64'd0);
        do_fetch(32'h0000_00A0, 20'h00011, 1'b0, h, e, r, ins, ma, rs);
        chk(h, "R6", "recently used line survives", {63'd0, h}, 64'd1);
        do_fetch(32'h0000_00A0, 20'h00022, 1'b0, h, e, r, ins, ma, rs);
        chk(!h, "R6", "least recent line evicted", {63'd0, h}, 64'd0);
    endtask

    task automatic t_parity();
        bit h, e, r, rs; logic [31:0] ins, ma;
        bad_beat = 2;
        do_fetch(32'h0000_0120, 20'h0AAAA, 1'b0, h, e, r, ins, ma, rs);
        chk(ins == exp_instr(32'h0000_0120, 20'h0AAAA), "R5", "clean word of line",
            ins, exp_instr(32'h0000_0120, 20'h0AAAA));
        do_fetch(32'h0000_0130, 20'h0AAAA, 1'b0, h, e, r, ins, ma, rs);
        chk(!h && e, "R8", "bad parity word reports error", {62'd0, h, e}, 64'd1);
        chk(ma == {20'h0AAAA, 7'd9, 5'd0}, "R8", "error refill address",
            ma, {20'h0AAAA, 7'd9, 5'd0});
        chk(ins == exp_instr(32'h0000_0130, 20'h0AAAA), "R8", "word after error refill",
            ins, exp_instr(32'h0000_0130, 20'h0AAAA));
    endtask

    task automatic pulse_inv(input logic [6:0] s, input logic w);
        inv_valid = 1'b1;
        inv_set = s;
        inv_way = w;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic t_invalidate();
        bit h, e, r, rs; logic [31:0] ins, ma;
        pulse_inv(7'd9, 1'b1);
        do_fetch(32'h0000_0120, 20'h0AAAA, 1'b0, h, e, r, ins, ma, rs);
        chk(h, "R9", "other way untouched", {63'd0, h}, 64'd1);
        pulse_inv(7'd9, 1'b0);
        do_fetch(32'h0000_0124, 20'h0AAAA, 1'b0, h, e, r, ins, ma, rs);
        chk(!h && r, "R9", "invalidated line misses, no reuse", {62'd0, h, r}, 64'd1);
        chk(ins == exp_instr(32'h0000_0124, 20'h0AAAA), "R9", "refetched word",
            ins, exp_instr(32'h0000_0124, 20'h0AAAA));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_miss();
        t_hit_and_reuse();
        t_index_tag();
        t_lru();
        t_parity();
        t_invalidate();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule